// File: doc/BRIEF.md
# Lockable Region Register Bank

This block stores the configuration of eight protected memory regions. Each region has four 32-bit words: a low address, a high address, a read-permission mask and a write-permission mask. Software reaches the words through a small word-addressed register port made of an index, a write enable, write data and a combinational read-data return. The stored values of every region are also driven in parallel to a downstream access filter, which decides whether each agent may read or write.

Each region can be sealed. A write to the low-address word with bit 31 set seals the region and, in the same write, stores the address bits carried with it. Software is expected to program the address first and to seal in a later write. After the region is sealed, all four of its words ignore writes until the next reset. Each region's seal is held in a two-state machine. The states are `SLOT_OPEN` and `SLOT_SEALED`. The transition *seal* goes from `SLOT_OPEN` to `SLOT_SEALED` on a sealing write. The only other transition is *reset*, which forces `SLOT_OPEN` from either state. `SLOT_SEALED` has no way back to `SLOT_OPEN` except reset.

Reset loads every region with the disabled encoding: both address words zero, the read mask `0xBFFFFFFF`, the write mask `0xFFFFFFFF`, and the region open.

Top module: `isoreg_bank`

## Requirements
- R1: After reset, every region reads low address 0 with bit 31 clear, high address 0, read mask 0xBFFFFFFF and write mask 0xFFFFFFFF, and `rgn_locked` is 0 for every region.
- R2: Word index 0x40 + 4·n + k addresses region n (n = 0..7). k = 0 selects the low address, 1 the high address, 2 the read mask and 3 the write mask. A write to an open region takes effect at the clock edge where `reg_we` is sampled. Reads are combinational from the current contents.
- R3: Only bits 23:2 of the two address words are stored. Bits 30:24 and 1:0 of the low word, and bits 31:24 and 1:0 of the high word, always read as zero. Bit 31 of the low word reads the region's seal state.
- R4: Both mask words store and return all 32 bits as written.
- R5: A write to the low word of an open region with bit 31 = 1 seals the region and stores that write's address bits. A write with bit 31 = 0, or bit 31 set in any other word, leaves the region open.
- R6: While a region is sealed, writes to any of its four words are discarded.
- R7: The seal is cleared only by reset. Writing bit 31 = 0 to a sealed low word leaves the region sealed. After a reset the region accepts writes again.
- R8: Writes to indices outside 0x40..0x5F change nothing, and reads there return zero.
- R9: The `rgn_*` outputs carry, for every region at once, the same four word values that a read would return, and `rgn_locked` carries each region's seal state.
- R10: A write or seal on one region leaves all other regions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores disabled defaults |
| reg_idx | input | 8 | Word index of the register access |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| rgn_lo | output | 256 | Low-address word of each region, 32 bits per region (region n at bits 32n+31:32n) |
| rgn_hi | output | 256 | High-address word of each region, 32 bits per region |
| rgn_rmask | output | 256 | Read mask of each region, 32 bits per region |
| rgn_wmask | output | 256 | Write mask of each region, 32 bits per region |
| rgn_locked | output | 8 | Seal state of each region, one bit per region |

## Verification
The bench sweeps every word of every region with data that sets the reserved bits. A design that stored whole address words would read back non-zero reserved fields. Sealing writes carry fresh address bits, so a design that sealed without loading the address, or that sealed on bit 31 of a mask word, shows a wrong low word or a wrong `rgn_locked`. After half the regions are sealed, the bench rewrites all 32 words and tries to unseal with bit 31 = 0. A seal that freezes only the low word, or that software can clear, leaves changed words or an open region. Every out-of-window index is written with all ones and read back. A reset in the middle of the run must reopen sealed regions, which catches a seal held outside reset.

// File: rtl/isoreg_pkg.sv
package isoreg_pkg;
    localparam int WORD_W = 32;

    // Position of the seal flag in the low-address word.
    localparam int SEAL_POS = 31;

    // Address bits kept in both address words.
    localparam logic [WORD_W-1:0] ADDR_KEEP = 32'h00FF_FFFC;

    // Disabled-region defaults for the two masks.
    localparam logic [WORD_W-1:0] RD_ALL = 32'hBFFF_FFFF;
    localparam logic [WORD_W-1:0] WR_ALL = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        W_LO = 2'd0,
        W_HI = 2'd1,
        W_RD = 2'd2,
        W_WR = 2'd3
    } word_sel_e;

    typedef enum logic {
        SLOT_OPEN   = 1'b0,
        SLOT_SEALED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/isoreg_decode.sv
module isoreg_decode
    import isoreg_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BASE = 64,
    parameter int NUM  = 8,
    parameter int SW   = 3
) (
    input  logic [AW-1:0] idx,
    output logic          hit,
    output logic [SW-1:0] slot,
    output word_sel_e     word
);
    localparam logic [31:0] LO_B = 32'(BASE);
    localparam logic [31:0] HI_B = 32'(BASE + NUM * 4);

    logic [31:0] idx_w;
    logic [31:0] rel;

    assign idx_w = 32'(idx);
    assign rel   = idx_w - LO_B;
    assign hit   = (idx_w >= LO_B) && (idx_w < HI_B);
    assign slot  = SW'(rel >> 2);
    assign word  = word_sel_e'(rel[1:0]);
endmodule

// File: rtl/isoreg_slot.sv
module isoreg_slot
    import isoreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_sel_e         word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q,
    output logic [WORD_W-1:0] rm_q,
    output logic [WORD_W-1:0] wm_q,
    output logic              sealed
);
    slot_state_e       state_q, state_d;
    logic              store;
    logic [WORD_W-1:0] lo_r, hi_r, rm_r, wm_r;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_OPEN;
        else        state_q <= state_d;
    end

    // Next state and store permission.
    always_comb begin
        state_d = state_q;
        store   = 1'b0;
        unique case (state_q)
            SLOT_OPEN: begin
                store = wr_en;
                if (wr_en && word == W_LO && wdata[SEAL_POS])
                    state_d = SLOT_SEALED;
            end
            SLOT_SEALED: begin
                store = 1'b0;
            end
        endcase
    end

    // Word storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_r <= '0;
            hi_r <= '0;
            rm_r <= RD_ALL;
            wm_r <= WR_ALL;
        end else if (store) begin
            unique case (word)
                W_LO: lo_r <= wdata & ADDR_KEEP;
                W_HI: hi_r <= wdata & ADDR_KEEP;
                W_RD: rm_r <= wdata;
                W_WR: wm_r <= wdata;
            endcase
        end
    end

    assign sealed = (state_q == SLOT_SEALED);
    assign lo_q   = lo_r | {sealed, {(WORD_W-1){1'b0}}};
    assign hi_q   = hi_r;
    assign rm_q   = rm_r;
    assign wm_q   = wm_r;

    // R7: the seal never drops without reset.
    a_r7_seal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SLOT_SEALED |=> state_q == SLOT_SEALED);

    // R6: a sealed region keeps all four words.
    a_r6_sealed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SLOT_SEALED |=> ($stable(lo_r) && $stable(hi_r)
                                    && $stable(rm_r) && $stable(wm_r)));

    // R5: a sealing write seals the region and loads its address bits.
    a_r5_seal_loads_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_OPEN && wr_en && word == W_LO && wdata[SEAL_POS])
        |=> (sealed && lo_r == ($past(wdata) & ADDR_KEEP)));

    // R5: nothing else seals the region.
    a_r5_no_spurious_seal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_OPEN && !(wr_en && word == W_LO && wdata[SEAL_POS]))
        |=> state_q == SLOT_OPEN);
endmodule

// File: rtl/isoreg_bank.sv
module isoreg_bank
    import isoreg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int AW          = 8,
    parameter int BASE        = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 reg_idx,
    input  logic                          reg_we,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_lo,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_hi,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_rmask,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_wmask,
    output logic [NUM_REGIONS-1:0]        rgn_locked
);
    localparam int SW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic              hit;
    logic [SW-1:0]     slot;
    word_sel_e         word;
    logic [NUM_REGIONS-1:0] sel;
    logic [WORD_W-1:0] lo_w [NUM_REGIONS];
    logic [WORD_W-1:0] hi_w [NUM_REGIONS];
    logic [WORD_W-1:0] rm_w [NUM_REGIONS];
    logic [WORD_W-1:0] wm_w [NUM_REGIONS];

    isoreg_decode #(
        .AW   (AW),
        .BASE (BASE),
        .NUM  (NUM_REGIONS),
        .SW   (SW)
    ) u_dec (
        .idx  (reg_idx),
        .hit  (hit),
        .slot (slot),
        .word (word)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        assign sel[g] = hit && (slot == SW'(g));

        isoreg_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (reg_we && sel[g]),
            .word   (word),
            .wdata  (reg_wdata),
            .lo_q   (lo_w[g]),
            .hi_q   (hi_w[g]),
            .rm_q   (rm_w[g]),
            .wm_q   (wm_w[g]),
            .sealed (rgn_locked[g])
        );

        assign rgn_lo[g*WORD_W +: WORD_W]    = lo_w[g];
        assign rgn_hi[g*WORD_W +: WORD_W]    = hi_w[g];
        assign rgn_rmask[g*WORD_W +: WORD_W] = rm_w[g];
        assign rgn_wmask[g*WORD_W +: WORD_W] = wm_w[g];
    end

    // Read return.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            unique case (word)
                W_LO: reg_rdata = lo_w[slot];
                W_HI: reg_rdata = hi_w[slot];
                W_RD: reg_rdata = rm_w[slot];
                W_WR: reg_rdata = wm_w[slot];
            endcase
        end
    end

    // R10: an access targets at most one region.
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R8: out-of-window reads return zero.
    a_r8_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> reg_rdata == '0);

    // R8: out-of-window writes change no seal.
    a_r8_oob_no_seal: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && reg_we) |=> $stable(rgn_locked));
endmodule

// File: tb/sim_isoreg_bank.sv
module sim_isoreg_bank;
    localparam int N    = 8;
    localparam int BASE = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      idx = '0;
    logic            we = 1'b0;
    logic [31:0]     wd = '0;
    logic [31:0]     rdata;
    logic [N*32-1:0] o_lo, o_hi, o_rm, o_wm;
    logic [N-1:0]    o_lk;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_rm [N];
    logic [31:0] m_wm [N];
    logic        m_lk [N];

    always #10 clk = ~clk;

    isoreg_bank #(.NUM_REGIONS(N), .AW(8), .BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_idx(idx), .reg_we(we),
        .reg_wdata(wd), .reg_rdata(rdata), .rgn_lo(o_lo), .rgn_hi(o_hi),
        .rgn_rmask(o_rm), .rgn_wmask(o_wm), .rgn_locked(o_lk)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int n = 0; n < N; n++) begin
            m_lo[n] = 32'h0;
            m_hi[n] = 32'h0;
            m_rm[n] = 32'hBFFF_FFFF;
            m_wm[n] = 32'hFFFF_FFFF;
            m_lk[n] = 1'b0;
        end
    endtask

    function automatic logic [31:0] exp_word(int a);
        int r = a - BASE;
        int n = r >> 2;
        if (a < BASE || a >= BASE + 4 * N) return 32'h0;
        case (r & 3)
            0: return m_lo[n] | {m_lk[n], 31'h0};
            1: return m_hi[n];
            2: return m_rm[n];
            default: return m_wm[n];
        endcase
    endfunction

    task automatic model_wr(int a, logic [31:0] d);
        int r = a - BASE;
        int n = r >> 2;
        if (a >= BASE && a < BASE + 4 * N && !m_lk[n]) begin
            case (r & 3)
                0: begin m_lo[n] = d & 32'h00FF_FFFC; m_lk[n] = d[31]; end
                1: m_hi[n] = d & 32'h00FF_FFFC;
                2: m_rm[n] = d;
                default: m_wm[n] = d;
            endcase
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        idx = 8'(a); wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(string tag, int a);
        idx = 8'(a);
        #2;
        chk(tag, rdata, exp_word(a));
    endtask

    task automatic full_chk(string tag);
        for (int a = BASE; a < BASE + 4 * N; a++) rd_chk(tag, a);
        for (int n = 0; n < N; n++) begin
            chk({tag, " R9 lo"}, o_lo[n*32 +: 32], exp_word(BASE + 4*n));
            chk({tag, " R9 hi"}, o_hi[n*32 +: 32], exp_word(BASE + 4*n + 1));
            chk({tag, " R9 rm"}, o_rm[n*32 +: 32], exp_word(BASE + 4*n + 2));
            chk({tag, " R9 wm"}, o_wm[n*32 +: 32], exp_word(BASE + 4*n + 3));
            chk({tag, " R9 lk"}, 32'(o_lk[n]), 32'(m_lk[n]));
        end
    endtask

    function automatic logic [31:0] pat(int n, int k, logic [31:0] seed);
        logic [31:0] d = seed ^ (32'(n) * 32'h0101_0101) ^ (32'(k) << 28);
        if (k == 0) d = (d | 32'h7F00_0003) & 32'h7FFF_FFFF;
        if (k == 1) d = d | 32'hFF00_0003;
        return d;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        full_chk("R1 reset");

        // R2 R3 R4: every word, reserved bits driven high
        for (int n = 0; n < N; n++)
            for (int k = 0; k < 4; k++)
                wr(BASE + 4*n + k, pat(n, k, 32'hA5C3_5A3C));
        full_chk("R2/R3/R4 pattern");

        // R5: seal even regions, the sealing write carries new address bits
        for (int n = 0; n < N; n += 2)
            wr(BASE + 4*n, 32'hFF00_0003 | (32'(n + 1) << 12));
        full_chk("R5 seal");

        // R5: bit 31 in a mask word must not seal an odd region
        for (int n = 1; n < N; n += 2) wr(BASE + 4*n + 2, 32'h8000_0000);
        full_chk("R5 mask bit31");

        // R6 R10: rewrite everything; sealed regions stay put
        for (int n = 0; n < N; n++)
            for (int k = 0; k < 4; k++)
                wr(BASE + 4*n + k, pat(n, k, 32'h1E2D_3C4B));
        full_chk("R6/R10 rewrite");

        // R7: attempt to clear seals by software
        for (int n = 0; n < N; n += 2) wr(BASE + 4*n, 32'h0000_0000);
        full_chk("R7 unseal attempt");

        // R8: out-of-window writes and reads
        for (int a = 0; a < 256; a++)
            if (a < BASE || a >= BASE + 4 * N) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 256; a++)
            if (a < BASE || a >= BASE + 4 * N) rd_chk("R8 oob read", a);
        full_chk("R8 after oob");

        // R1 R7: reset reopens the sealed regions
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        full_chk("R1/R7 mid reset");
        for (int n = 0; n < N; n += 2) wr(BASE + 4*n + 1, 32'h0012_3404);
        full_chk("R7 writable after reset");

        finish_run();
    end
endmodule